// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Capture

This block holds a small set of waiting slots for one class of floating-point operation. The issue logic places an instruction into a free slot. Each source operand arrives either as a value or as the tag of the slot that will later produce it. While a slot waits, it watches a shared result bus. When the tag on the bus matches a pending operand, the slot copies the value and stops waiting on it. Every slot whose operands are both present may start, regardless of when it was issued. The functional unit sits outside the block as an opaque fixed-latency pipeline, so the pool only signals a start and names the slot that started.

A slot stays occupied from issue until its own result appears on the bus under its own tag. Once that happens, the slot can take a new instruction. Tags are nonzero and unique across every pool on the bus. Producer tag zero marks an operand as already present.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free: `iss_ready_o` is 1, `iss_tag_o` equals `TAG_BASE` and `ex_valid_o` is 0.
- R2: An accepted issue takes the lowest-indexed free slot, and that slot's tag is `TAG_BASE` plus its index. `iss_tag_o` shows the tag that the next issue will receive.
- R3: When all slots are occupied, `iss_ready_o` is 0 and an issue request is dropped without effect. The dropped instruction never starts.
- R4: A slot issued with both producer tags zero starts in the cycle after issue. `ex_op_o`, `ex_vj_o`, `ex_vk_o` and `ex_tag_o` carry its operation, its two operand values and its own tag.
- R5: A slot with a nonzero producer tag on either operand never starts.
- R6: A bus cycle whose tag equals a pending producer tag replaces that operand with the bus value and clears the tag. All matching slots capture in the same cycle. A slot that becomes ready this way may start in the following cycle.
- R7: A slot issued in the same cycle as a bus transfer that matches one of its issued producer tags holds the bus value, not the tag.
- R8: At most one slot starts per cycle, and the lowest-indexed ready slot wins. A slot that has started never starts again before it is freed.
- R9: A started slot is freed by a bus transfer carrying its own tag, and it can take an issue from the next cycle.
- R10: A bus transfer whose tag matches no pending operand and no started slot changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code |
| iss_vj_i | input | DATA_W | First operand value, used when iss_qj_i is 0 |
| iss_vk_i | input | DATA_W | Second operand value, used when iss_qk_i is 0 |
| iss_qj_i | input | TAG_W | Producer tag of first operand, 0 = present |
| iss_qk_i | input | TAG_W | Producer tag of second operand, 0 = present |
| iss_ready_o | output | 1 | A slot is free |
| iss_tag_o | output | TAG_W | Tag that the next accepted issue receives |
| bc_valid_i | input | 1 | Result bus transfer valid |
| bc_tag_i | input | TAG_W | Tag of the producing slot |
| bc_value_i | input | DATA_W | Result value |
| ex_valid_o | output | 1 | A slot starts this cycle |
| ex_op_o | output | OP_W | Operation of the started slot |
| ex_vj_o | output | DATA_W | First operand of the started slot |
| ex_vk_o | output | DATA_W | Second operand of the started slot |
| ex_tag_o | output | TAG_W | Tag of the started slot |

## Verification
The bench builds the pool with its defaults: three slots, tags 1 to 3, 3-bit tags and 32-bit data. With so few slots, filling the pool takes only three issues, which brings the structural stall within reach. Foreign tags 5 to 7 then stand in for other pools on the shared bus. Two slots waiting on the same tag show simultaneous capture and the lowest-index start order. An issue that coincides with a matching bus transfer shows capture at issue.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_NUM_RS  = 3;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_TAG_W   = 3;
  localparam int unsigned DEF_OP_W    = 4;
  localparam int unsigned DEF_TAG_BASE = 1;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = rs_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned OP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  own_tag_i,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_value_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  logic              busy_q, run_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] vj_q, vk_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic hit_j, hit_k, iss_hit_j, iss_hit_k, done;

  assign hit_j     = bc_valid_i && (qj_q != '0) && (bc_tag_i == qj_q);
  assign hit_k     = bc_valid_i && (qk_q != '0) && (bc_tag_i == qk_q);
  assign iss_hit_j = bc_valid_i && (iss_qj_i != '0) && (bc_tag_i == iss_qj_i);
  assign iss_hit_k = bc_valid_i && (iss_qk_i != '0) && (bc_tag_i == iss_qk_i);
  assign done      = busy_q && run_q && bc_valid_i && (bc_tag_i == own_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      op_q   <= '0;
      vj_q   <= '0;
      vk_q   <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      run_q  <= 1'b0;
      op_q   <= iss_op_i;
      // capture a result that lands in the issue cycle
      if (iss_hit_j) begin
        vj_q <= bc_value_i;
        qj_q <= '0;
      end else begin
        vj_q <= iss_vj_i;
        qj_q <= iss_qj_i;
      end
      if (iss_hit_k) begin
        vk_q <= bc_value_i;
        qk_q <= '0;
      end else begin
        vk_q <= iss_vk_i;
        qk_q <= iss_qk_i;
      end
    end else if (busy_q) begin
      if (hit_j) begin
        vj_q <= bc_value_i;
        qj_q <= '0;
      end
      if (hit_k) begin
        vk_q <= bc_value_i;
        qk_q <= '0;
      end
      if (start_i) run_q <= 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        run_q  <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !run_q && (qj_q == '0) && (qk_q == '0);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;

  AST_START_OPERANDS_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (busy_q && !run_q && qj_q == '0 && qk_q == '0)); // R5

  AST_CAPTURE_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && hit_j) |=> (qj_q == '0 && vj_q == $past(bc_value_i))); // R6

  AST_CAPTURE_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && hit_k) |=> (qk_q == '0 && vk_q == $past(bc_value_i))); // R6

  AST_ISSUE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && iss_hit_j) |=> (qj_q == '0 && vj_q == $past(bc_value_i))); // R7

  AST_FREE_ON_OWN_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_q); // R9

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !done) |=> run_q); // R8
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int unsigned NUM_RS   = rs_pkg::DEF_NUM_RS,
  parameter int unsigned DATA_W   = rs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rs_pkg::DEF_TAG_W,
  parameter int unsigned OP_W     = rs_pkg::DEF_OP_W,
  parameter int unsigned TAG_BASE = rs_pkg::DEF_TAG_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_value_i,
  output logic              ex_valid_o,
  output logic [OP_W-1:0]   ex_op_o,
  output logic [DATA_W-1:0] ex_vj_o,
  output logic [DATA_W-1:0] ex_vk_o,
  output logic [TAG_W-1:0]  ex_tag_o
);
  localparam int unsigned IW = rs_pkg::idx_w(NUM_RS);

  logic [NUM_RS-1:0] busy_vec, ready_vec, free_gnt, start_gnt, alloc_vec;
  logic [IW-1:0]     free_idx, start_idx;
  logic              any_free, any_ready;
  logic [OP_W-1:0]   op_arr [NUM_RS];
  logic [DATA_W-1:0] vj_arr [NUM_RS];
  logic [DATA_W-1:0] vk_arr [NUM_RS];

  rs_prio_pick #(.N(NUM_RS), .IW(IW)) u_free_pick (
    .req_i (~busy_vec),
    .gnt_o (free_gnt),
    .idx_o (free_idx),
    .any_o (any_free)
  );

  rs_prio_pick #(.N(NUM_RS), .IW(IW)) u_start_pick (
    .req_i (ready_vec),
    .gnt_o (start_gnt),
    .idx_o (start_idx),
    .any_o (any_ready)
  );

  assign alloc_vec = (iss_valid_i && any_free) ? free_gnt : '0;

  for (genvar g = 0; g < NUM_RS; g++) begin : g_rs
    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(TAG_BASE + g);
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .own_tag_i  (OWN_TAG),
      .alloc_i    (alloc_vec[g]),
      .iss_op_i   (iss_op_i),
      .iss_vj_i   (iss_vj_i),
      .iss_vk_i   (iss_vk_i),
      .iss_qj_i   (iss_qj_i),
      .iss_qk_i   (iss_qk_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_value_i (bc_value_i),
      .start_i    (start_gnt[g]),
      .busy_o     (busy_vec[g]),
      .ready_o    (ready_vec[g]),
      .op_o       (op_arr[g]),
      .vj_o       (vj_arr[g]),
      .vk_o       (vk_arr[g])
    );
  end

  always_comb begin
    ex_op_o = '0;
    ex_vj_o = '0;
    ex_vk_o = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (start_gnt[i]) begin
        ex_op_o = op_arr[i];
        ex_vj_o = vj_arr[i];
        ex_vk_o = vk_arr[i];
      end
    end
  end

  assign ex_valid_o  = any_ready;
  assign ex_tag_o    = TAG_W'(TAG_BASE) + TAG_W'(start_idx);
  assign iss_ready_o = any_free;
  assign iss_tag_o   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_gnt)); // R8

  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_vec & busy_vec) == '0); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_ready_o && !bc_valid_i) |=> !iss_ready_o); // R3

  AST_ALLOC_TAKES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o) |=> ($countones(busy_vec) >= 1)); // R2
endmodule

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAG_W  = 3;
  localparam int unsigned OP_W   = 4;

  typedef struct {
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] vj;
    logic [DATA_W-1:0] vk;
    logic [TAG_W-1:0]  tag;
    string             req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic              iss_valid_i = 1'b0;
  logic [OP_W-1:0]   iss_op_i = '0;
  logic [DATA_W-1:0] iss_vj_i = '0, iss_vk_i = '0;
  logic [TAG_W-1:0]  iss_qj_i = '0, iss_qk_i = '0;
  logic              iss_ready_o;
  logic [TAG_W-1:0]  iss_tag_o;
  logic              bc_valid_i = 1'b0;
  logic [TAG_W-1:0]  bc_tag_i = '0;
  logic [DATA_W-1:0] bc_value_i = '0;
  logic              ex_valid_o;
  logic [OP_W-1:0]   ex_op_o;
  logic [DATA_W-1:0] ex_vj_o, ex_vk_o;
  logic [TAG_W-1:0]  ex_tag_o;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t exp_q[$];
  bit done_flag = 1'b0;

  always #4 clk_i = ~clk_i;

  rs_pool u_dut (
    .clk_i, .rst_ni, .iss_valid_i, .iss_op_i, .iss_vj_i, .iss_vk_i,
    .iss_qj_i, .iss_qk_i, .iss_ready_o, .iss_tag_o, .bc_valid_i,
    .bc_tag_i, .bc_value_i, .ex_valid_o, .ex_op_o, .ex_vj_o, .ex_vk_o,
    .ex_tag_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every start must match the next expected item
  always @(negedge clk_i) begin
    if (rst_ni && ex_valid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R3/R8: unexpected start actual tag=%0d op=%0d expected none",
                 ex_tag_o, ex_op_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (ex_op_o !== e.op || ex_vj_o !== e.vj || ex_vk_o !== e.vk || ex_tag_o !== e.tag) begin
          n_bad++;
          $display("FAIL %s: actual op=%0d vj=%0h vk=%0h tag=%0d expected op=%0d vj=%0h vk=%0h tag=%0d",
                   e.req, ex_op_o, ex_vj_o, ex_vk_o, ex_tag_o, e.op, e.vj, e.vk, e.tag);
        end
      end
    end
  end

  task automatic push(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] vj,
                      input logic [DATA_W-1:0] vk, input logic [TAG_W-1:0] tag,
                      input string req);
    exp_t e;
    e.op = op; e.vj = vj; e.vk = vk; e.tag = tag; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic iv, input logic [OP_W-1:0] op,
                       input logic [DATA_W-1:0] vj, input logic [DATA_W-1:0] vk,
                       input logic [TAG_W-1:0] qj, input logic [TAG_W-1:0] qk,
                       input logic bv, input logic [TAG_W-1:0] bt,
                       input logic [DATA_W-1:0] bval);
    iss_valid_i = iv; iss_op_i = op; iss_vj_i = vj; iss_vk_i = vk;
    iss_qj_i = qj; iss_qk_i = qk;
    bc_valid_i = bv; bc_tag_i = bt; bc_value_i = bval;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      drive(1'b0, '0, '0, '0, '0, '0, 1'b0, '0, '0);
    end
  endtask

  task automatic issue(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] vj,
                       input logic [DATA_W-1:0] vk, input logic [TAG_W-1:0] qj,
                       input logic [TAG_W-1:0] qk);
    @(negedge clk_i);
    drive(1'b1, op, vj, vk, qj, qk, 1'b0, '0, '0);
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
    @(negedge clk_i);
    drive(1'b0, '0, '0, '0, '0, '0, 1'b1, t, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", 32'(iss_ready_o), 1);
    chk("R1 tag", 32'(iss_tag_o), 1);
    chk("R1 no start", 32'(ex_valid_o), 0);

    // R4: ready operands start next cycle
    chk("R2 first tag", 32'(iss_tag_o), 1);
    push(4'd1, 32'd10, 32'd20, 3'd1, "R4");
    issue(4'd1, 32'd10, 32'd20, 3'd0, 3'd0);
    idle(1);
    chk("R2 next tag", 32'(iss_tag_o), 2);
    idle(1);
    // R9: own tag frees slot 0
    bcast(3'd1, 32'd30);
    idle(1);
    chk("R9 freed tag", 32'(iss_tag_o), 1);
    chk("R9 freed ready", 32'(iss_ready_o), 1);

    // R5/R6: two slots wait on foreign tag 5
    issue(4'd2, 32'hdead, 32'd7, 3'd5, 3'd0);
    @(negedge clk_i);
    chk("R2 second slot tag", 32'(iss_tag_o), 2);
    drive(1'b1, 4'd3, 32'd3, 32'hbeef, 3'd0, 3'd5, 1'b0, '0, '0);
    idle(3);
    // R10: unrelated tag ignored
    bcast(3'd7, 32'd123);
    idle(2);
    push(4'd2, 32'd99, 32'd7, 3'd1, "R6/R8 first waiter");
    push(4'd3, 32'd3, 32'd99, 3'd2, "R6/R8 second waiter");
    bcast(3'd5, 32'd99);
    idle(3);

    // R3: fill pool, then a dropped issue
    @(negedge clk_i);
    chk("R2 third slot tag", 32'(iss_tag_o), 3);
    drive(1'b1, 4'd4, 32'hfeed, 32'd8, 3'd6, 3'd0, 1'b0, '0, '0);
    @(negedge clk_i);
    chk("R3 full", 32'(iss_ready_o), 0);
    drive(1'b1, 4'd7, 32'd1, 32'd1, 3'd0, 3'd0, 1'b0, '0, '0);
    idle(2);
    chk("R3 still full", 32'(iss_ready_o), 0);
    bcast(3'd1, 32'd0);
    bcast(3'd2, 32'd0);
    idle(1);
    chk("R9 lowest free again", 32'(iss_tag_o), 1);

    // R7: issue coincides with matching result; waiting slot 2 also captures
    push(4'd5, 32'd44, 32'd1, 3'd1, "R7");
    push(4'd4, 32'd44, 32'd8, 3'd3, "R6/R10");
    @(negedge clk_i);
    drive(1'b1, 4'd5, 32'hbad0, 32'd1, 3'd6, 3'd0, 1'b1, 3'd6, 32'd44);
    idle(3);
    bcast(3'd1, 32'd0);
    bcast(3'd3, 32'd0);

    // R5/R6: both operands pending on different tags
    issue(4'd6, 32'h1111, 32'h2222, 3'd5, 3'd6);
    bcast(3'd5, 32'd11);
    idle(2);
    push(4'd6, 32'd11, 32'd22, 3'd1, "R5/R6 two tags");
    bcast(3'd6, 32'd22);
    idle(2);
    bcast(3'd1, 32'd0);
    idle(1);
    chk("R9 all free ready", 32'(iss_ready_o), 1);
    chk("R9 all free tag", 32'(iss_tag_o), 1);
    chk("R8 pending starts left", 32'(exp_q.size()), 0);

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule